// File: doc/BRIEF.md
# Round-Robin Arbiter with Merged Data Selector

This block shares one output channel among N requesters with round-robin fairness, and it selects the data in the same pass. Each input has one request bit and one data word of W bits. In every cycle the block grants at most one active request. It flags that a grant exists and places the granted input's data word on the output. All of this is combinational from the request and data inputs. A registered priority state then moves so that the input just served becomes the least preferred in the next round.

The priority state is a thermometer-coded vector. Positions with a set bit form the preferred segment and positions with a clear bit form the non-preferred segment. Each position forms a 2-bit symbol with the value 2·request + priority. A balanced tree of comparison nodes finds the rightmost largest symbol, which is the same as a cyclic search for the next request, without any cyclic wiring. Each node has a direction flag. The same flag steers a 2-to-1 data selector and the winner's index, so one tree does both the arbitration and the multiplexing. When N is not a power of two, the tree is padded with idle leaves.

Top module: `rrm_arb_top`

## Requirements
- R1: While reset is held and right after its release, the priority vector is all ones. With every request active, input 0 is therefore granted first.
- R2: `grantVec` has at most one bit set. A set bit is always on an active request, and `grantVec` is all zeros when `reqVec` is zero.
- R3: `anyGrant` is high exactly when at least one bit of `reqVec` is set.
- R4: Let the lowest set bit of the priority vector be the scan start. The granted input is the first active request met when scanning upward from that position and wrapping from N-1 to 0.
- R5: When no preferred position (priority bit 1) has an active request, the lowest-indexed active request is granted.
- R6: After a cycle that grants input i, the priority vector holds ones exactly at positions above i. A grant to input N-1 leaves the vector all zeros, so the next scan starts at 0.
- R7: A cycle with no active request leaves the priority vector unchanged.
- R8: When `anyGrant` is high, `dataOut` equals the granted input's word, which is lane i of `dataIn` at bits [i*W +: W].
- R9: When no request is active, `dataOut` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqVec | input | N | One request bit per input |
| dataIn | input | N*W | Packed data words, input i in bits [i*W +: W] |
| grantVec | output | N | One-hot grant, zero when idle |
| anyGrant | output | 1 | High when some input is granted |
| dataOut | output | W | Data word of the granted input |

## Verification
The bench builds the block with N = 5 and W = 12. Five is not a power of two, so the padded leaves of an eight-leaf tree are in play. The wrap from input 4 to input 0 arrives within a handful of cycles, so both directed sequences and a long random stream pass through every pointer position many times. Random data words in every cycle expose any selector that follows the wrong direction flag.

// File: rtl/rrm_pkg.sv
package rrm_pkg;

  // Strobes from the control part to the datapath
  typedef struct packed {
    logic prioLoad;   // take the next priority vector at the clock edge
  } rrmStrobe_t;

endpackage

// File: rtl/rrm_node.sv
// One comparison node: keeps the larger symbol, preferring the right side on a tie,
// and steers data and index with the same direction flag.
module rrm_node #(
  parameter int W  = 8,
  parameter int IW = 3
) (
  input  logic [1:0]    symL,
  input  logic [1:0]    symR,
  input  logic [W-1:0]  datL,
  input  logic [W-1:0]  datR,
  input  logic [IW-1:0] idxL,
  input  logic [IW-1:0] idxR,
  output logic [1:0]    symO,
  output logic [W-1:0]  datO,
  output logic [IW-1:0] idxO
);

  logic leftWins;

  always_comb begin
    leftWins = (symL > symR);
    symO     = leftWins ? symL : symR;
    datO     = leftWins ? datL : datR;
    idxO     = leftWins ? idxL : idxR;
  end

endmodule

// File: rtl/rrm_ctrl.sv
// Control: decides when priority moves and which thermometer vector it moves to.
module rrm_ctrl
  import rrm_pkg::*;
#(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic          anyGrant,
  input  logic [IW-1:0] winIdx,
  output rrmStrobe_t    strobe,
  output logic [N-1:0]  nextPrio
);

  always_comb begin
    strobe.prioLoad = anyGrant;
    for (int j = 0; j < N; j++) begin
      nextPrio[j] = (IW'(j) > winIdx);
    end
  end

endmodule

// File: rtl/rrm_datapath.sv
// Datapath: priority register, symbol leaves, comparison tree, grant decode.
module rrm_datapath
  import rrm_pkg::*;
#(
  parameter int N  = 8,
  parameter int W  = 8,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [N-1:0]  reqVec,
  input  logic [N*W-1:0] dataIn,
  input  rrmStrobe_t    strobe,
  input  logic [N-1:0]  nextPrio,
  output logic [N-1:0]  prioVec,
  output logic          anyGrant,
  output logic [IW-1:0] winIdx,
  output logic [N-1:0]  grantVec,
  output logic [W-1:0]  dataOut
);

  localparam int NP = 1 << IW;   // leaves after padding

  // Heap layout: node k has children 2k (lower indices, right) and 2k+1 (left)
  logic [1:0]    symH [1:2*NP-1];
  logic [W-1:0]  datH [1:2*NP-1];
  logic [IW-1:0] idxH [1:2*NP-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prioVec <= '1;
    end else if (strobe.prioLoad) begin
      prioVec <= nextPrio;
    end
  end

  genvar i, k;
  generate
    for (i = 0; i < NP; i++) begin : gLeaf
      assign idxH[NP+i] = IW'(i);
      if (i < N) begin : gReal
        assign symH[NP+i] = {reqVec[i], prioVec[i]};
        assign datH[NP+i] = dataIn[i*W +: W];
      end else begin : gPad
        assign symH[NP+i] = 2'd0;
        assign datH[NP+i] = '0;
      end
    end

    for (k = 1; k < NP; k++) begin : gNode
      rrm_node #(.W(W), .IW(IW)) uNode (
        .symL (symH[2*k+1]),
        .symR (symH[2*k]),
        .datL (datH[2*k+1]),
        .datR (datH[2*k]),
        .idxL (idxH[2*k+1]),
        .idxR (idxH[2*k]),
        .symO (symH[k]),
        .datO (datH[k]),
        .idxO (idxH[k])
      );
    end

    for (i = 0; i < N; i++) begin : gGrant
      assign grantVec[i] = anyGrant && (idxH[1] == IW'(i));
    end
  endgenerate

  assign anyGrant = symH[1][1];
  assign winIdx   = idxH[1];
  assign dataOut  = anyGrant ? datH[1] : '0;

endmodule

// File: rtl/rrm_arb_top.sv
module rrm_arb_top
  import rrm_pkg::*;
#(
  parameter int N = 8,
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [N-1:0]   reqVec,
  input  logic [N*W-1:0] dataIn,
  output logic [N-1:0]   grantVec,
  output logic           anyGrant,
  output logic [W-1:0]   dataOut
);

  localparam int IW = (N > 1) ? $clog2(N) : 1;

  rrmStrobe_t    strobe;
  logic [N-1:0]  nextPrio;
  logic [N-1:0]  prioVec;
  logic [IW-1:0] winIdx;

  rrm_ctrl #(.N(N), .IW(IW)) uCtrl (
    .anyGrant (anyGrant),
    .winIdx   (winIdx),
    .strobe   (strobe),
    .nextPrio (nextPrio)
  );

  rrm_datapath #(.N(N), .W(W), .IW(IW)) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .reqVec   (reqVec),
    .dataIn   (dataIn),
    .strobe   (strobe),
    .nextPrio (nextPrio),
    .prioVec  (prioVec),
    .anyGrant (anyGrant),
    .winIdx   (winIdx),
    .grantVec (grantVec),
    .dataOut  (dataOut)
  );

endmodule

// File: rtl/rrm_arb_chk.sv
module rrm_arb_chk #(
  parameter int N = 8,
  parameter int W = 16
) (
  input logic           clk,
  input logic           rstN,
  input logic [N-1:0]   reqVec,
  input logic [N*W-1:0] dataIn,
  input logic [N-1:0]   grantVec,
  input logic           anyGrant,
  input logic [W-1:0]   dataOut,
  input logic [N-1:0]   prioVec
);

  function automatic logic [W-1:0] laneOf(input logic [N-1:0] g, input logic [N*W-1:0] d);
    logic [W-1:0] r;
    r = '0;
    for (int j = 0; j < N; j++) if (g[j]) r = d[j*W +: W];
    return r;
  endfunction

  logic [N-1:0] invPrio;
  assign invPrio = ~prioVec;

  assert_onehot_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantVec) && ((grantVec & ~reqVec) == '0));

  assert_any_R3: assert property (@(posedge clk) disable iff (!rstN)
    anyGrant == (reqVec != '0));

  assert_thermo_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((invPrio & (invPrio + 1'b1)) == '0));

  assert_rotate_R6: assert property (@(posedge clk) disable iff (!rstN)
    (anyGrant && $countones(reqVec) > 1) |=>
      ((reqVec != $past(reqVec)) || (grantVec != $past(grantVec))));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !anyGrant |=> $stable(prioVec));

  assert_data_R8: assert property (@(posedge clk) disable iff (!rstN)
    anyGrant |-> (dataOut == laneOf(grantVec, dataIn)));

  assert_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !anyGrant |-> (dataOut == '0));

endmodule

bind rrm_arb_top rrm_arb_chk #(.N(N), .W(W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .reqVec   (reqVec),
  .dataIn   (dataIn),
  .grantVec (grantVec),
  .anyGrant (anyGrant),
  .dataOut  (dataOut),
  .prioVec  (prioVec)
);

// File: tb/tb_rrm_arb_top.sv
`timescale 1ns/1ps
module tb_rrm_arb_top;

  localparam int N = 5;
  localparam int W = 12;

  logic           clk = 1'b0;
  logic           rstN;
  logic [N-1:0]   reqVec;
  logic [N*W-1:0] dataIn;
  logic [N-1:0]   grantVec;
  logic           anyGrant;
  logic [W-1:0]   dataOut;

  int compared = 0;
  int mismatched = 0;
  int scanStart = 0;   // model: where the cyclic search begins

  always #5 clk = ~clk;

  rrm_arb_top #(.N(N), .W(W)) dut (
    .clk(clk), .rstN(rstN), .reqVec(reqVec), .dataIn(dataIn),
    .grantVec(grantVec), .anyGrant(anyGrant), .dataOut(dataOut)
  );

  task automatic checkVal(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Drive one cycle, compare against the cyclic-search model, then advance the model.
  task automatic step(input logic [N-1:0] req, input string tag);
    int win;
    logic [N-1:0] expG;
    logic [W-1:0] expD;
    @(negedge clk);
    reqVec = req;
    for (int j = 0; j < N; j++) dataIn[j*W +: W] = W'($urandom);
    #2;
    win = -1;
    for (int k = 0; k < N; k++) begin
      int pos;
      pos = (scanStart + k) % N;
      if (win < 0 && req[pos]) win = pos;
    end
    expG = '0;
    expD = '0;
    if (win >= 0) begin
      expG[win] = 1'b1;
      expD = dataIn[win*W +: W];
    end
    checkVal({tag, " R2/R4/R5 grant"}, 32'(grantVec), 32'(expG));
    checkVal({tag, " R3 anyGrant"}, 32'(anyGrant), 32'(win >= 0));
    checkVal({tag, win >= 0 ? " R8 data" : " R9 idle data"}, 32'(dataOut), 32'(expD));
    if (win >= 0) scanStart = (win + 1) % N;   // R6; idle keeps it (R7)
  endtask

  initial begin
    #1500000;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    reqVec = '0;
    dataIn = '0;
    #1;
    // R1: during reset, all-ones priority -> full request grants input 0
    reqVec = '1;
    #1;
    checkVal("R1 reset grant", 32'(grantVec), 32'd1);
    reqVec = '0;
    #1;
    checkVal("R9 reset idle data", 32'(dataOut), 32'd0);
    checkVal("R2 reset idle grant", 32'(grantVec), 32'd0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1/R4/R6: full requests rotate 0,1,2,3,4,0,...
    step('1, "R1 first after reset");
    for (int c = 0; c < 9; c++) step('1, "R4 rotate full");

    // R5: only low-index requests while pointer sits above them
    step(5'b00100, "R4 single");          // grant 2, start 3
    step(5'b00011, "R5 wrap to low");     // grant 0
    step(5'b10000, "R6 top input");       // grant 4, prio all zero
    step(5'b10010, "R6 after top wraps"); // grant 1

    // R7: idle cycles keep the pointer
    step(5'b00100, "R7 set pointer");     // grant 2, start 3
    for (int c = 0; c < 4; c++) step('0, "R7 idle");
    step('1, "R7 after idle");            // grant 3

    // Random streams, sparse and dense
    for (int c = 0; c < 1500; c++) step(N'($urandom), "R4 random");
    for (int c = 0; c < 500; c++) step(N'($urandom) | N'($urandom), "R5 dense random");
    for (int c = 0; c < 500; c++) step(N'($urandom) & N'($urandom) & N'($urandom), "R7 sparse random");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule